// File: doc/BRIEF.md
# Walking-ones data bus tester

This controller checks the data lines between a master and a simple synchronous memory. When started it captures a test address and then, at that one address, writes a word with exactly one bit set, reads the same word back in the very next cycle, and compares it against what was written. It moves the set bit from the least significant position upward, one position per pattern, until shifting it left once more would leave no bit set. With N data lines this costs N write/read pairs instead of trying every possible value.

The first mismatch ends the run at once. The result is zero when every pattern came back intact. Otherwise it is the pattern that failed, so its single set bit names the first faulty data line. A one-cycle done pulse marks the end of a run. The pass flag and the failing pattern stay unchanged until the next accepted start.

Read data is taken to be valid a fixed, parameterised number of cycles after the read request. When the data bus fans out to several memory devices, the caller runs the block once per device, each time with an address inside that device.

Top module: `wlk_tester`

## Requirements
- R1: The k-th write of a run (k counted from 0) carries the word with only bit k set: 1, 2, 4 and so on up to the most significant bit. No other values are written.
- R2: A run in which every pattern reads back correctly makes exactly DW writes and ends after the most-significant-bit pattern.
- R3: Every memory access of a run uses the address sampled on `test_addr_i` in the cycle the start was accepted. A start raised while a run is in progress is ignored.
- R4: Each write (`mem_en_o`=1, `mem_we_o`=1) is followed in the next cycle by a read (`mem_en_o`=1, `mem_we_o`=0) of the same address. No second write comes before that read.
- R5: For a read request in cycle t, `mem_rdata_i` is compared only in cycle t+RD_LAT. The value on it in any other cycle has no effect.
- R6: At the first mismatch the block makes no further memory access, drives `pass_o`=0 and sets `fail_pat_o` to the pattern that failed.
- R7: When all DW patterns match, `pass_o`=1 and `fail_pat_o`=0.
- R8: `done_o` is high for exactly one cycle, the cycle after the comparison that ends the run, which is cycle t+RD_LAT+1 for the final read in cycle t.
- R9: `pass_o` and `fail_pat_o` hold their values until a start is accepted. An accepted start clears both to 0 from the next cycle on.
- R10: While in reset and until the first start, `mem_en_o`, `done_o`, `pass_o` and `fail_pat_o` are all 0.
- R11: A mismatch on the most-significant-bit pattern, which is also the last one, is reported as a failure (`pass_o`=0, `fail_pat_o` with only the MSB set), never as a pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run; accepted only while idle |
| test_addr_i | input | AW | Address at which all patterns are applied |
| mem_en_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read, valid with `mem_en_o` |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Write data (current pattern) |
| mem_rdata_i | input | DW | Read data, valid RD_LAT cycles after the read request |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | 1 when the last run found no faulty line |
| fail_pat_o | output | DW | First failing pattern, 0 on success |

## Verification
Two collisions matter. The comparison of the last pattern is also the point where the sequence would wrap to zero, so a mismatch and normal completion fall in the same cycle. A memory model with the top data line stuck low provokes this, and the run is judged by a fail result that names the MSB rather than a pass. The second collision is a new start in the very cycle `done_o` is high. Runs are issued back to back for this, and the bench checks that the old results are cleared in the next cycle and that the new run goes through a full, correctly ordered write/read sequence.

// File: rtl/wlk_pkg.sv
package wlk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2,
    ST_WAIT = 2'd3
  } wlk_state_e;

endpackage

// File: rtl/wlk_pattern_gen.sv
module wlk_pattern_gen #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          active_i,
  output logic [DW-1:0] pat_o,
  output logic          wrap_o
);

  logic [DW-1:0] pat_q;
  logic [DW-1:0] pat_d;
  logic [DW-1:0] shl;
  logic          pat_en;

  assign shl    = {pat_q[DW-2:0], 1'b0};
  assign wrap_o = (shl == '0);
  assign pat_en = load_i | adv_i;

  always_comb begin
    pat_d = pat_q;
    if (load_i) begin
      pat_d = {{(DW-1){1'b0}}, 1'b1};
    end else if (adv_i) begin
      pat_d = shl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= '0;
    end else if (pat_en) begin
      pat_q <= pat_d;
    end
  end

  assign pat_o = pat_q;

  // R1: only one bit set while a run uses the pattern
  assert_single_hot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> ($countones(pat_q) == 1));

  // R1: advancing moves the bit exactly one place up
  assert_step_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> (pat_q == {$past(pat_q[DW-2:0]), 1'b0}));

endmodule

// File: rtl/wlk_lat_timer.sv
module wlk_lat_timer #(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic run_i,
  output logic expire_o
);

  localparam int CW = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(RD_LAT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en   = arm_i | (run_i && (cnt_q != '0));
  assign expire_o = run_i && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (arm_i) begin
      cnt_d = LOAD_VAL;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R5: a wait that has not expired keeps counting down
  assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !expire_o && !arm_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/wlk_ctrl.sv
module wlk_ctrl
  import wlk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       expire_i,
  input  logic       match_i,
  input  logic       wrap_i,
  output wlk_state_e state_o,
  output logic       accept_o,
  output logic       adv_o,
  output logic       arm_o,
  output logic       run_o,
  output logic       fail_o,
  output logic       pass_o
);

  wlk_state_e state_q;
  wlk_state_e state_d;

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    adv_o    = 1'b0;
    arm_o    = 1'b0;
    run_o    = 1'b0;
    fail_o   = 1'b0;
    pass_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          state_d  = ST_WR;
        end
      end
      ST_WR: begin
        state_d = ST_RD;
      end
      ST_RD: begin
        arm_o   = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        run_o = 1'b1;
        if (expire_i) begin
          if (!match_i) begin
            fail_o  = 1'b1;
            state_d = ST_IDLE;
          end else if (wrap_i) begin
            pass_o  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            adv_o   = 1'b1;
            state_d = ST_WR;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

  // R3: a start seen outside idle never restarts the sequence
  assert_busy_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD) |=> (state_q == ST_WAIT));

  // R6: an ending comparison returns to idle
  assert_end_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o || pass_o) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/wlk_result.sv
module wlk_result #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          fail_i,
  input  logic          pass_i,
  input  logic [DW-1:0] pat_i,
  output logic          done_o,
  output logic          pass_o,
  output logic [DW-1:0] fail_pat_o
);

  logic          done_q;
  logic          pass_q;
  logic [DW-1:0] fpat_q;
  logic          pass_d;
  logic [DW-1:0] fpat_d;
  logic          pass_en;
  logic          fpat_en;

  assign pass_en = clr_i | fail_i | pass_i;
  assign fpat_en = clr_i | fail_i;

  always_comb begin
    pass_d = pass_i;
    fpat_d = fail_i ? pat_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fpat_q <= '0;
    end else begin
      done_q <= fail_i | pass_i;
      if (pass_en) begin
        pass_q <= pass_d;
      end
      if (fpat_en) begin
        fpat_q <= fpat_d;
      end
    end
  end

  assign done_o     = done_q;
  assign pass_o     = pass_q;
  assign fail_pat_o = fpat_q;

  // R8: single-cycle completion pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: a pass reports a zero pattern
  assert_pass_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && pass_q) |-> (fpat_q == '0));

  // R9: results only move on a start or a run end
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !fail_i && !pass_i) |=> ($stable(pass_q) && $stable(fpat_q)));

endmodule

// File: rtl/wlk_tester.sv
module wlk_tester
  import wlk_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AW     = 10,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] test_addr_i,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          pass_o,
  output logic [DW-1:0] fail_pat_o
);

  logic [1:0]    rs_q;
  logic          rst_n_int;
  wlk_state_e    state;
  logic          accept;
  logic          adv;
  logic          arm;
  logic          run;
  logic          fire_fail;
  logic          fire_pass;
  logic          expire;
  logic          match;
  logic          wrap;
  logic          active;
  logic [DW-1:0] pat;
  logic [AW-1:0] addr_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_n_int = rs_q[1];

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= test_addr_i;
    end
  end

  assign match  = (mem_rdata_i == pat);
  assign active = (state != ST_IDLE);

  wlk_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start_i  (start_i),
    .expire_i (expire),
    .match_i  (match),
    .wrap_i   (wrap),
    .state_o  (state),
    .accept_o (accept),
    .adv_o    (adv),
    .arm_o    (arm),
    .run_o    (run),
    .fail_o   (fire_fail),
    .pass_o   (fire_pass)
  );

  wlk_pattern_gen #(.DW(DW)) u_pat (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load_i   (accept),
    .adv_i    (adv),
    .active_i (active),
    .pat_o    (pat),
    .wrap_o   (wrap)
  );

  wlk_lat_timer #(.RD_LAT(RD_LAT)) u_lat (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .arm_i    (arm),
    .run_i    (run),
    .expire_o (expire)
  );

  wlk_result #(.DW(DW)) u_res (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .clr_i      (accept),
    .fail_i     (fire_fail),
    .pass_i     (fire_pass),
    .pat_i      (pat),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .fail_pat_o (fail_pat_o)
  );

  assign mem_en_o    = (state == ST_WR) || (state == ST_RD);
  assign mem_we_o    = (state == ST_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = pat;

  // R4: every write is read back in the next cycle at the same address
  assert_write_then_read_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mem_en_o && mem_we_o) |=> (mem_en_o && !mem_we_o && (mem_addr_o == $past(mem_addr_o))));

  // R3: the address does not move between consecutive accesses
  assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mem_en_o && $past(mem_en_o)) |-> (mem_addr_o == $past(mem_addr_o)));

  // R6: nothing is accessed after a mismatch
  assert_stop_on_mismatch_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    fire_fail |=> (!mem_en_o && !pass_o && (fail_pat_o == $past(pat))));

  // R11: a mismatch on the last pattern is a failure
  assert_last_fail_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    (fire_fail && wrap) |=> (!pass_o && fail_pat_o[DW-1]));

endmodule

// File: tb/wlk_tester_bench.sv
`timescale 1ns/100ps
module wlk_tester_bench;

  localparam int DW  = 8;
  localparam int AW  = 10;
  localparam int LAT = 3;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] test_addr_i;
  logic          mem_en_o;
  logic          mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic [DW-1:0] mem_rdata_i;
  logic          done_o;
  logic          pass_o;
  logic [DW-1:0] fail_pat_o;

  wlk_tester #(.DW(DW), .AW(AW), .RD_LAT(LAT)) u_wlk_tester (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .test_addr_i (test_addr_i),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .done_o      (done_o),
    .pass_o      (pass_o),
    .fail_pat_o  (fail_pat_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  // fault model: 0 none, 1 line fa stuck low, 2 line fa stuck high, 3 lines fa/fb wired-OR
  int f_kind = 0;
  int f_a    = 0;
  int f_b    = 1;

  function automatic logic [DW-1:0] flt(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = v;
    case (f_kind)
      1: r[f_a] = 1'b0;
      2: r[f_a] = 1'b1;
      3: if (v[f_a] | v[f_b]) begin r[f_a] = 1'b1; r[f_b] = 1'b1; end
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [DW-1:0] exp_result();
    for (int k = 0; k < DW; k++) begin
      logic [DW-1:0] p;
      p = '0;
      p[k] = 1'b1;
      if (flt(p) != p) return p;
    end
    return '0;
  endfunction

  function automatic int exp_writes(input logic [DW-1:0] e);
    for (int k = 0; k < DW; k++) if (e[k]) return k + 1;
    return DW;
  endfunction

  // memory model with fixed read latency; stale cycles show all ones
  logic [DW-1:0] mem [2**AW];
  logic [DW-1:0] dat [LAT];
  logic          vld [LAT];

  always @(posedge clk) begin
    if (mem_en_o && mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    vld[0] <= mem_en_o && !mem_we_o;
    dat[0] <= flt(mem[mem_addr_o]);
    for (int i = 1; i < LAT; i++) begin
      vld[i] <= vld[i-1];
      dat[i] <= dat[i-1];
    end
  end
  assign mem_rdata_i = vld[LAT-1] ? dat[LAT-1] : '1;

  // port monitor
  int            cyc = 0;
  int            wr_tot = 0, ones_tot = 0, acc_tot = 0;
  int            pat_err = 0, addr_err = 0, seq_err = 0, tim_err = 0;
  int            last_rd = 0;
  logic [DW-1:0] last_w = '0;
  logic          pend = 1'b0;
  logic [AW-1:0] cur_addr = '0;

  initial begin
    for (int i = 0; i < LAT; i++) begin vld[i] = 1'b0; dat[i] = '0; end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && mem_en_o) begin
      acc_tot <= acc_tot + 1;
      if (mem_addr_o != cur_addr) addr_err <= addr_err + 1;
      if (mem_we_o) begin
        wr_tot <= wr_tot + 1;
        if (mem_wdata_o == 1) ones_tot <= ones_tot + 1;
        if (mem_wdata_o != 1 && mem_wdata_o != (last_w << 1)) pat_err <= pat_err + 1;
        if (pend) seq_err <= seq_err + 1;
        last_w <= mem_wdata_o;
        pend   <= 1'b1;
      end else begin
        if (!pend) seq_err <= seq_err + 1;
        pend    <= 1'b0;
        last_rd <= cyc;
      end
    end
    if (rst_n && done_o && (cyc - last_rd != LAT + 1)) tim_err <= tim_err + 1;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic run(input logic [AW-1:0] a, input int kind, input int fa, input int fb,
                     input bit poke, input bit gap);
    logic [DW-1:0] e;
    int w0, o0, pe0, ae0, se0, te0, n, acc0;
    logic          hp;
    logic [DW-1:0] hf;
    f_kind = kind; f_a = fa; f_b = fb;
    e = exp_result();
    cur_addr = a;
    w0 = wr_tot; o0 = ones_tot; pe0 = pat_err; ae0 = addr_err; se0 = seq_err; te0 = tim_err;
    start_i = 1'b1; test_addr_i = a;
    tick();
    start_i = 1'b0; test_addr_i = ~a;
    chk(pass_o == 1'b0 && fail_pat_o == '0, "R9 clear on start", {pass_o, fail_pat_o}, 0);
    if (poke) begin
      tick(); tick();
      start_i = 1'b1; test_addr_i = a ^ 1;
      tick();
      start_i = 1'b0;
    end
    n = 0;
    while (done_o !== 1'b1 && n < 400) begin tick(); n++; end
    chk(done_o === 1'b1, "R8 done seen", done_o, 1);
    if (done_o !== 1'b1) return;
    chk(pass_o == (e == '0), "R7 pass flag", pass_o, e == '0);
    chk(fail_pat_o == e, "R6 failing pattern", fail_pat_o, e);
    if (e[DW-1]) chk(!pass_o && fail_pat_o == e, "R11 msb fails", fail_pat_o, e);
    chk(wr_tot - w0 == exp_writes(e), "R2 write count", wr_tot - w0, exp_writes(e));
    chk(ones_tot - o0 == 1 && pat_err == pe0, "R1 pattern order", pat_err - pe0, 0);
    chk(addr_err == ae0, "R3 address fixed", addr_err - ae0, 0);
    chk(seq_err == se0, "R4 read after write", seq_err - se0, 0);
    chk(tim_err == te0, "R5 R8 compare timing", tim_err - te0, 0);
    if (gap) begin
      acc0 = acc_tot; hp = pass_o; hf = fail_pat_o;
      tick();
      chk(done_o == 1'b0, "R8 one-cycle done", done_o, 0);
      repeat (4) tick();
      chk(pass_o == hp && fail_pat_o == hf, "R9 hold", {pass_o, fail_pat_o}, {hp, hf});
      chk(acc_tot == acc0, "R6 no access after end", acc_tot - acc0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; test_addr_i = '0;
    repeat (3) tick();
    chk(!mem_en_o && !done_o && !pass_o && fail_pat_o == '0, "R10 reset",
        {mem_en_o, done_o, pass_o, fail_pat_o}, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk(!mem_en_o && !done_o && !pass_o && fail_pat_o == '0, "R10 idle after reset",
        {mem_en_o, done_o, pass_o, fail_pat_o}, 0);

    run(10'h000, 0, 0, 1, 0, 1);            // clean bus, address 0
    run(10'h3FF, 0, 0, 1, 0, 1);            // clean bus, top address
    run(10'h155, 1, DW-1, 0, 0, 1);         // R11: MSB stuck low
    run(10'h2AA, 2, 0, 1, 0, 1);            // bit 0 stuck high -> fails at 2
    run(10'h0F0, 3, 5, 2, 0, 1);            // lines 5/2 bridged -> fails at 4
    run(10'h011, 1, 0, 1, 1, 1);            // R3: start poked while busy, fails at 1
    run(10'h122, 0, 0, 1, 1, 1);            // R3: poke on a clean run
    run(10'h033, 2, 3, 1, 0, 0);            // done cycle collides with next start
    run(10'h344, 0, 0, 1, 0, 1);

    for (int i = 0; i < 20; i++) begin
      int kind, fa, fb;
      kind = $urandom_range(0, 3);
      fa   = $urandom_range(0, DW-1);
      fb   = (fa + 1 + $urandom_range(0, DW-2)) % DW;
      run(AW'($urandom), kind, fa, fb, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    repeat (3) tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule